// File: doc/BRIEF.md
# Boot Memory Window Decoder

This block sits between a host-side memory cycle decoder and a local memory bus. For each host memory cycle it is shown, it decides whether the cycle should go to the local bus. A cycle is either a plain LPC memory cycle or a firmware-hub (FWH) cycle. The block claims cycles that fall in the legacy boot firmware ranges, in an optional extended legacy page, and in one programmable user zone. For a claimed cycle it passes on the lower 28 address bits. The hit outputs are combinational from the cycle inputs and the configuration state. Register writes and hardware updates take effect on the next rising clock edge.

The block identifies the host's boot protocol by itself. When the configuration straps select boot-enabled mode at reset, the LPC enable and the FWH enable both come up set. The first completed read that hits a boot range then clears the enable of the protocol that was not used. This happens once per reset. After it, software owns both bits.

Top module: `boot_win_decoder`

## Requirements
- R1: Reset is synchronous and active high. With `strap_cfg` = 3'b000 the control register (select 0) reads 8'h09, which is the LPC enable at bit 0 plus the FWH enable at bit 3. With any other strap value it reads 8'h00. The zone base bytes (selects 1 and 2) and the size code (select 3) reset to 0.
- R2: An LPC cycle (`cyc_fwh`=0) to 000F0000h..000FFFFFh or to FFC00000h..FFFFFFFFh asserts `bios_hit` and `hit` only while control bit 0 is set.
- R3: An LPC cycle to 000E0000h..000EFFFFh is claimed as a boot cycle only while both control bit 1 (extended page) and bit 0 are set.
- R4: An FWH cycle (`cyc_fwh`=1) asserts `bios_hit` only for FFC00000h..FFFFFFFFh, and only while control bit 3 is set. An FWH cycle to the legacy pages is never claimed.
- R5: In boot-enabled mode, the first completed read (`cyc_done`=1, `cyc_write`=0) that is an LPC boot hit clears control bit 3 on the next edge.
- R6: In boot-enabled mode, the first completed read that is an FWH boot hit clears control bit 0 on the next edge.
- R7: A completed write, and a completed read that is not a boot hit, leave the control bits unchanged.
- R8: After the first boot read, bits that software sets again stay set through later boot reads of either protocol.
- R9: When reset ran with a strap value other than 000, completed boot reads never clear a control bit.
- R10: The user zone base is {select 2 byte, select 1 byte, 16'h0000}. Size code k (select 3, 4 bits) gives a window of 64 KB << k. `zone_hit` asserts for an LPC cycle whose address ANDed with ~(size-1) equals the base, only while control bit 4 is set, and regardless of the boot enables.
- R11: `local_addr` always equals `cyc_addr[27:0]`.
- R12: A software write to the control register in the same cycle as the first boot read wins over the hardware clear, and the first-read detection is still used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_cfg | input | 3 | Configuration straps, sampled during reset |
| cyc_valid | input | 1 | A host memory cycle is presented |
| cyc_fwh | input | 1 | 1 = FWH cycle, 0 = LPC memory cycle |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_done | input | 1 | The presented cycle completes this clock |
| cyc_addr | input | 32 | Host memory address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 base low, 2 base high, 3 size |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register contents |
| hit | output | 1 | Cycle is claimed for the local bus |
| bios_hit | output | 1 | Claimed by a boot range |
| zone_hit | output | 1 | Claimed by the user zone |
| local_addr | output | 28 | Address for the local bus |

## Verification
A wrong enable bit or a wrong first-read flag does not show until the next boot-range cycle. It appears as a missing or extra `bios_hit` on that cycle, or as a wrong control readback one cycle after the read that should have cleared the bit. The bench checks the control register right after each completed read. It then probes both protocols in the top range, so a wrongly cleared or retained bit shows within two cycles. A wrong size mask shows only at the window edges, so the zone is probed at the last byte inside the window and the first bytes on either side of it.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_BASE_LO = 2'd1,
    SEL_BASE_HI = 2'd2,
    SEL_SIZE    = 2'd3
  } cfg_sel_e;

  localparam int CTRL_LPC_BIT  = 0;
  localparam int CTRL_EXT_BIT  = 1;
  localparam int CTRL_FWH_BIT  = 3;
  localparam int CTRL_ZONE_BIT = 4;

  localparam logic [7:0] CTRL_WMASK = 8'h1B;
  localparam logic [7:0] CTRL_BOOT_RESET = 8'h09;
  localparam logic [2:0] STRAP_BOOT_ON = 3'b000;
endpackage

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
  import bwd_pkg::*;
#(
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap_cfg,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              boot_rd_done,
  input  logic              boot_rd_fwh,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        base_lo_q,
  output logic [7:0]        base_hi_q,
  output logic [SIZE_W-1:0] size_q,
  output logic              first_seen_q,
  output logic [7:0]        cfg_rdata
);
  localparam int PAD_W = 8 - SIZE_W;

  logic boot_mode_q;
  logic auto_clr;
  logic ctrl_wr;

  assign ctrl_wr  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
  assign auto_clr = boot_mode_q && !first_seen_q && boot_rd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_mode_q  <= (strap_cfg == STRAP_BOOT_ON);
      ctrl_q       <= (strap_cfg == STRAP_BOOT_ON) ? CTRL_BOOT_RESET : 8'h00;
      first_seen_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= cfg_wdata & CTRL_WMASK;
      end else if (auto_clr) begin
        if (boot_rd_fwh) ctrl_q[CTRL_LPC_BIT] <= 1'b0;
        else             ctrl_q[CTRL_FWH_BIT] <= 1'b0;
      end
      if (boot_rd_done) first_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= 8'h00;
      base_hi_q <= 8'h00;
      size_q    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_BASE_LO: base_lo_q <= cfg_wdata;
        SEL_BASE_HI: base_hi_q <= cfg_wdata;
        SEL_SIZE:    size_q    <= cfg_wdata[SIZE_W-1:0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel_e'(cfg_sel))
      SEL_CTRL:    cfg_rdata = ctrl_q;
      SEL_BASE_LO: cfg_rdata = base_lo_q;
      SEL_BASE_HI: cfg_rdata = base_hi_q;
      default:     cfg_rdata = {{PAD_W{1'b0}}, size_q};
    endcase
  end
endmodule

// File: rtl/bwd_boot_dec.sv
module bwd_boot_dec #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 16,
  parameter int TOP_LSB  = 22
) (
  input  logic                       lpc_en,
  input  logic                       ext_en,
  input  logic                       fwh_en,
  input  logic                       cyc_fwh,
  input  logic [ADDR_W-1:PAGE_LSB]   addr_hi,
  output logic                       boot_hit
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam logic [PAGE_W-1:0] PAGE_F = PAGE_W'(16'h000F);
  localparam logic [PAGE_W-1:0] PAGE_E = PAGE_W'(16'h000E);

  logic in_top, in_f, in_e, lpc_range;

  assign in_top    = &addr_hi[ADDR_W-1:TOP_LSB];
  assign in_f      = (addr_hi == PAGE_F);
  assign in_e      = (addr_hi == PAGE_E);
  assign lpc_range = in_top || in_f || (ext_en && in_e);

  always_comb begin
    if (cyc_fwh) boot_hit = fwh_en && in_top;
    else         boot_hit = lpc_en && lpc_range;
  end
endmodule

// File: rtl/bwd_zone_dec.sv
module bwd_zone_dec #(
  parameter int ADDR_W  = 32,
  parameter int MIN_LOG = 16,
  parameter int SIZE_W  = 4
) (
  input  logic              zone_en,
  input  logic              cyc_fwh,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        base_lo,
  input  logic [7:0]        base_hi,
  input  logic [SIZE_W-1:0] size_code,
  output logic              zone_hit
);
  localparam int NCODE = 1 << SIZE_W;

  logic [ADDR_W-1:0] mask_tbl [NCODE];
  logic [ADDR_W-1:0] base;

  for (genvar i = 0; i < NCODE; i++) begin : g_mask
    localparam int LG = MIN_LOG + i;
    if (LG >= ADDR_W) begin : g_full
      assign mask_tbl[i] = '0;
    end else begin : g_part
      assign mask_tbl[i] = ~((ADDR_W'(1) << LG) - ADDR_W'(1));
    end
  end

  assign base     = ADDR_W'({base_hi, base_lo, {MIN_LOG{1'b0}}});
  assign zone_hit = zone_en && !cyc_fwh && ((addr & mask_tbl[size_code]) == base);
endmodule

// File: rtl/boot_win_decoder.sv
module boot_win_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LOCAL_W = 28,
  parameter int SIZE_W  = 4,
  parameter int MIN_LOG = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         strap_cfg,
  input  logic               cyc_valid,
  input  logic               cyc_fwh,
  input  logic               cyc_write,
  input  logic               cyc_done,
  input  logic [ADDR_W-1:0]  cyc_addr,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  output logic               hit,
  output logic               bios_hit,
  output logic               zone_hit,
  output logic [LOCAL_W-1:0] local_addr
);
  logic [7:0]        ctrl_q, base_lo_q, base_hi_q;
  logic [SIZE_W-1:0] size_q;
  logic              first_seen_q;
  logic              boot_raw, zone_raw, boot_rd_done;

  bwd_boot_dec #(.ADDR_W(ADDR_W), .PAGE_LSB(MIN_LOG), .TOP_LSB(ADDR_W-10)) u_boot (
    .lpc_en  (ctrl_q[CTRL_LPC_BIT]),
    .ext_en  (ctrl_q[CTRL_EXT_BIT]),
    .fwh_en  (ctrl_q[CTRL_FWH_BIT]),
    .cyc_fwh (cyc_fwh),
    .addr_hi (cyc_addr[ADDR_W-1:MIN_LOG]),
    .boot_hit(boot_raw)
  );

  bwd_zone_dec #(.ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG), .SIZE_W(SIZE_W)) u_zone (
    .zone_en  (ctrl_q[CTRL_ZONE_BIT]),
    .cyc_fwh  (cyc_fwh),
    .addr     (cyc_addr),
    .base_lo  (base_lo_q),
    .base_hi  (base_hi_q),
    .size_code(size_q),
    .zone_hit (zone_raw)
  );

  assign bios_hit     = cyc_valid && boot_raw;
  assign zone_hit     = cyc_valid && zone_raw;
  assign hit          = bios_hit || zone_hit;
  assign local_addr   = cyc_addr[LOCAL_W-1:0];
  assign boot_rd_done = bios_hit && cyc_done && !cyc_write;

  bwd_cfg_regs #(.SIZE_W(SIZE_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .strap_cfg   (strap_cfg),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .boot_rd_done(boot_rd_done),
    .boot_rd_fwh (cyc_fwh),
    .ctrl_q      (ctrl_q),
    .base_lo_q   (base_lo_q),
    .base_hi_q   (base_hi_q),
    .size_q      (size_q),
    .first_seen_q(first_seen_q),
    .cfg_rdata   (cfg_rdata)
  );
endmodule

// File: rtl/boot_win_decoder_chk.sv
module boot_win_decoder_chk #(
  parameter int ADDR_W  = 32,
  parameter int LOCAL_W = 28
) (
  input logic               clk,
  input logic               rst,
  input logic               cyc_valid,
  input logic               cyc_fwh,
  input logic               cyc_write,
  input logic               cyc_done,
  input logic [ADDR_W-1:0]  cyc_addr,
  input logic               cfg_we,
  input logic [1:0]         cfg_sel,
  input logic               bios_hit,
  input logic [LOCAL_W-1:0] local_addr,
  input logic [7:0]         ctrl_q,
  input logic               first_seen_q
);
  // R2
  lpc_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bios_hit && !cyc_fwh) |-> ctrl_q[0]);

  // R3
  ext_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bios_hit && !cyc_fwh && cyc_addr[ADDR_W-1:16] == 16'h000E) |-> ctrl_q[1]);

  // R4
  fwh_top_chk: assert property (@(posedge clk) disable iff (rst)
    (bios_hit && cyc_fwh) |-> (ctrl_q[3] && (&cyc_addr[ADDR_W-1:ADDR_W-10])));

  // R7
  fwh_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_q[3]) |-> ($past(cfg_we && cfg_sel == 2'd0) ||
                          $past(cyc_done && !cyc_write && bios_hit && !cyc_fwh)));

  // R8
  lpc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctrl_q[0]) && $past(first_seen_q)) |-> $past(cfg_we && cfg_sel == 2'd0));

  // R11
  local_addr_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> (local_addr == cyc_addr[LOCAL_W-1:0]));
endmodule

bind boot_win_decoder boot_win_decoder_chk #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_valid   (cyc_valid),
  .cyc_fwh     (cyc_fwh),
  .cyc_write   (cyc_write),
  .cyc_done    (cyc_done),
  .cyc_addr    (cyc_addr),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .bios_hit    (bios_hit),
  .local_addr  (local_addr),
  .ctrl_q      (ctrl_q),
  .first_seen_q(first_seen_q)
);

// File: tb/boot_win_decoder_tb.sv
`timescale 1ns/1ps
module boot_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  strap_cfg = 3'b000;
  logic        cyc_valid = 1'b0, cyc_fwh = 1'b0, cyc_write = 1'b0, cyc_done = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        hit, bios_hit, zone_hit;
  logic [27:0] local_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  rd;
    logic        h, bh, zh;
    logic [27:0] la;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  boot_win_decoder u_dut (
    .clk(clk), .rst(rst), .strap_cfg(strap_cfg),
    .cyc_valid(cyc_valid), .cyc_fwh(cyc_fwh), .cyc_write(cyc_write),
    .cyc_done(cyc_done), .cyc_addr(cyc_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hit(hit), .bios_hit(bios_hit),
    .zone_hit(zone_hit), .local_addr(local_addr)
  );

  // monitor: compares one queued item 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (e.is_rd) begin
          if (cfg_rdata !== e.rd) begin
            bad++;
            $display("FAIL %s: rdata=%h expected %h", t, cfg_rdata, e.rd);
          end
        end else if ({hit, bios_hit, zone_hit} !== {e.h, e.bh, e.zh} || local_addr !== e.la) begin
          bad++;
          $display("FAIL %s: hit/bios/zone=%b%b%b la=%h expected %b%b%b la=%h",
                   t, hit, bios_hit, zone_hit, local_addr, e.h, e.bh, e.zh, e.la);
        end
      end
    end
  end

  task automatic idle();
    cyc_valid = 0; cyc_done = 0; cyc_write = 0; cyc_fwh = 0; cfg_we = 0;
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    idle(); strap_cfg = s; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    idle(); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic done_cycle(input logic [31:0] a, input logic f, input logic w,
                            input logic we, input logic [7:0] d);
    @(negedge clk);
    idle();
    cyc_valid = 1; cyc_done = 1; cyc_addr = a; cyc_fwh = f; cyc_write = w;
    cfg_we = we; cfg_sel = 2'd0; cfg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic exp_reg(input logic [1:0] sel, input logic [7:0] v, input string t);
    exp_t e;
    @(negedge clk);
    idle(); cfg_sel = sel;
    e = '0; e.is_rd = 1; e.rd = v;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic probe(input logic [31:0] a, input logic f, input logic eb,
                       input logic ez, input string t);
    exp_t e;
    @(negedge clk);
    idle(); cyc_valid = 1; cyc_addr = a; cyc_fwh = f;
    e = '0; e.h = eb | ez; e.bh = eb; e.zh = ez; e.la = a[27:0];
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(3'b000);
    exp_reg(2'd0, 8'h09, "R1 ctrl boot mode");
    exp_reg(2'd1, 8'h00, "R1 base lo");
    exp_reg(2'd3, 8'h00, "R1 size");
    probe(32'h000F_1234, 0, 1, 0, "R2 lpc F page");
    probe(32'hFFC0_0010, 0, 1, 0, "R2 lpc top; R11 local addr");
    probe(32'h000E_0000, 0, 0, 0, "R3 E page without ext");
    probe(32'hFFFF_0000, 1, 1, 0, "R4 fwh top");
    probe(32'h000F_0000, 1, 0, 0, "R4 fwh legacy page not claimed");
    probe(32'hFFBF_FFFF, 1, 0, 0, "R4 fwh just below top");
    // R7: completed write and non-boot read leave bits alone
    done_cycle(32'h000F_0000, 0, 1, 0, 8'h00);
    exp_reg(2'd0, 8'h09, "R7 after boot write");
    done_cycle(32'h0010_0000, 0, 0, 0, 8'h00);
    exp_reg(2'd0, 8'h09, "R7 after non-boot read");
    // R5
    done_cycle(32'h000F_0000, 0, 0, 0, 8'h00);
    exp_reg(2'd0, 8'h01, "R5 lpc first read clears fwh");
    probe(32'hFFFF_0000, 1, 0, 0, "R5 fwh no longer claimed");
    // R8
    wr_reg(2'd0, 8'h0B);
    exp_reg(2'd0, 8'h0B, "R8 software re-enable");
    done_cycle(32'hFFFF_0000, 1, 0, 0, 8'h00);
    exp_reg(2'd0, 8'h0B, "R8 later fwh read keeps bits");
    probe(32'h000E_8000, 0, 1, 0, "R3 E page with ext");
    // R10 zone 0x12340000, 256 KB
    wr_reg(2'd1, 8'h34);
    wr_reg(2'd2, 8'h12);
    wr_reg(2'd3, 8'h02);
    probe(32'h1234_0000, 0, 0, 0, "R10 zone disabled");
    wr_reg(2'd0, 8'h1B);
    probe(32'h1237_FFFF, 0, 0, 1, "R10 zone last byte");
    probe(32'h1238_0000, 0, 0, 0, "R10 zone above");
    probe(32'h1233_FFFF, 0, 0, 0, "R10 zone below");
    probe(32'h1234_0000, 1, 0, 0, "R10 zone ignores fwh");
    wr_reg(2'd0, 8'h10);
    probe(32'h1235_0000, 0, 0, 1, "R10 zone independent of boot enables");
    probe(32'h000F_0000, 0, 0, 0, "R2 lpc cleared not claimed");
    // R6
    do_reset(3'b000);
    done_cycle(32'hFFC0_0000, 1, 0, 0, 8'h00);
    exp_reg(2'd0, 8'h08, "R6 fwh first read clears lpc");
    probe(32'h000F_0000, 0, 0, 0, "R6 lpc no longer claimed");
    // R12
    do_reset(3'b000);
    done_cycle(32'h000F_0000, 0, 0, 1, 8'h09);
    exp_reg(2'd0, 8'h09, "R12 write wins over clear");
    done_cycle(32'h000F_0000, 0, 0, 0, 8'h00);
    exp_reg(2'd0, 8'h09, "R12 detection used up");
    // R9
    do_reset(3'b101);
    exp_reg(2'd0, 8'h00, "R1 ctrl boot disabled");
    probe(32'h000F_0000, 0, 0, 0, "R9 nothing claimed");
    wr_reg(2'd0, 8'h09);
    done_cycle(32'h000F_0000, 0, 0, 0, 8'h00);
    exp_reg(2'd0, 8'h09, "R9 no auto clear");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule